// File: doc/BRIEF.md
# Row Control Packet Receiver

This block sits on the controller-to-memory request path and listens to a three-wire row control bus. A row control packet takes four clock cycles on that bus. In each cycle every wire carries two bits: an early bit and a late bit. That gives 24 bits per packet. The block finds the start of each packet and collects the four beats. It then rebuilds the device, bank and row-or-opcode fields and decides whether the packet is meant for this device.

Two signals in the first beat do double duty. The early bits on the top and middle wires form a dual-rail pair. That pair tells the receiver whether a packet is present, whether it is a broadcast, and the value of device address bit 4. One flag inside the packet selects the layout of the remaining 11 bits:
- an activate packet carries a row address;
- an operation packet carries an opcode in the same positions.

For every accepted packet the block raises a one-cycle strobe and presents the decoded fields. It also keeps a single active/standby status bit for this device. A directed activate packet sets that bit, and an explicit clear input resets it.

Top module: `row_pkt_rx`

## Requirements
- R1: Wire order is top = bit 2, middle = bit 1, bottom = bit 0 of both `ctl_early` and `ctl_late`. While idle, a cycle where `ctl_early[2:1]` is nonzero is beat 0 of a packet. The next three cycles are captured as beats 1 to 3 without looking for a new start. While idle, a cycle with `ctl_early[2:1]` = 00 starts nothing, whatever the other wires carry.
- R2: The pair {`ctl_early[2]`, `ctl_early[1]`} in beat 0 is decoded as follows:
  - 01: device bit 4 = 0.
  - 10: device bit 4 = 1.
  - 11: broadcast. `pkt_dev` then reports bit 4 as 0.
- R3: A packet is accepted when it is a broadcast, or when its full 5-bit device address equals `dev_id`. Any other packet produces no strobe and leaves all outputs and the status bit unchanged.
- R4: For an accepted packet, `pkt_valid` is high for exactly one cycle: the cycle after beat 3. The fields are valid in that cycle.
- R5: Device bits 3 to 0 are taken from:
  - bit 3: beat 0 early, bottom wire;
  - bit 2: beat 0 late, top wire;
  - bit 1: beat 0 late, middle wire;
  - bit 0: beat 0 late, bottom wire.

  Bank bits 0 to 4 are taken from:
  - bits 0, 1, 2: beat 1 early, on top, middle and bottom;
  - bits 3, 4: beat 1 late, on top and middle.

  The beat 1 late bottom bit is reserved and has no effect on any output.
- R6: The activate flag is the beat 2 early bottom bit: 1 = activate (row address), 0 = operation (opcode). The 11-bit argument is assembled the same way for both kinds:
  - bits 10, 9: beat 2 early, top and middle;
  - bits 8, 7, 6: beat 2 late, top/middle/bottom;
  - bits 5, 4, 3: beat 3 early, top/middle/bottom;
  - bits 2, 1, 0: beat 3 late, top/middle/bottom.
- R7: A new packet may start in the cycle right after beat 3 of the previous one. Both packets are then decoded.
- R8: An accepted, non-broadcast activate packet sets `dev_active` to 1. This happens at the same edge that raises `pkt_valid`, whatever the previous state of `dev_active`.
- R9: Broadcast packets and operation packets never change `dev_active`.
- R10: `active_clear` high at a rising edge sets `dev_active` to 0. If a directed activate completes at the same edge, the activation wins.
- R11: Synchronous active-high `rst` clears `pkt_valid`, `dev_active` and any partly captured packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_id | input | 5 | Address of this device |
| ctl_early | input | 3 | Early bit of each wire in the current cycle (2 = top, 0 = bottom) |
| ctl_late | input | 3 | Late bit of each wire in the current cycle |
| active_clear | input | 1 | Returns the status bit to standby |
| pkt_valid | output | 1 | One-cycle strobe for an accepted packet |
| pkt_bcast | output | 1 | Accepted packet was a broadcast |
| pkt_activate | output | 1 | 1 = activate (row), 0 = operation (opcode) |
| pkt_dev | output | 5 | Device address of the packet |
| pkt_bank | output | 5 | Bank address |
| pkt_arg | output | 11 | Row address or opcode |
| dev_active | output | 1 | 1 = active, 0 = standby |

## Verification
There is one register between beat 3 and the outputs. The strobe and decoded fields are therefore due in the cycle after the beat 3 rising edge. The status bit changes at that same edge, and after an `active_clear` edge it changes one cycle later. The bench drives every beat on a falling edge and reads results on the falling edge that follows the beat 3 rising edge. For back-to-back packets, it reads the first packet's results before driving beat 0 of the next. The main sweep covers:
- all 32 device IDs against all 32 addresses;
- both packet kinds;
- the reserved bit toggled.

Expected fields are rebuilt in the bench from per-wire bit tables.

// File: rtl/row_pkt_pkg.sv
package row_pkt_pkg;

  localparam int unsigned RP_WIRES  = 3;
  localparam int unsigned RP_BEATS  = 4;
  localparam int unsigned RP_BEAT_W = 2 * RP_WIRES;
  localparam int unsigned RP_PKT_W  = RP_BEAT_W * RP_BEATS;
  localparam int unsigned RP_DEV_W  = 5;
  localparam int unsigned RP_BANK_W = 5;
  localparam int unsigned RP_ARG_W  = 11;

  // Packed word: half-cycle h occupies bits [23-3h -: 3] as {top,mid,bot}.
  typedef logic [RP_PKT_W-1:0] pkt_word_t;

  // Dual-rail pair {top, mid} of beat 0 early half.
  typedef enum logic [1:0] {
    PAIR_NONE = 2'b00,
    PAIR_LO   = 2'b01,
    PAIR_HI   = 2'b10,
    PAIR_ALL  = 2'b11
  } pair_e;

  typedef struct packed {
    logic                 bcast;
    logic                 activate;
    logic [RP_DEV_W-1:0]  dev;
    logic [RP_BANK_W-1:0] bank;
    logic [RP_ARG_W-1:0]  arg;
  } row_fields_t;

  function automatic pair_e pair_of(input pkt_word_t w);
    return pair_e'(w[23:22]);
  endfunction

  function automatic logic [RP_DEV_W-1:0] dev_of(input pkt_word_t w);
    logic hi;
    hi = (pair_of(w) == PAIR_HI);
    return {hi, w[21], w[20], w[19], w[18]};
  endfunction

  function automatic logic [RP_BANK_W-1:0] bank_of(input pkt_word_t w);
    // bank bits 0..4 sit in bits 17..13; bit 12 is reserved
    return {w[13], w[14], w[15], w[16], w[17]};
  endfunction

  function automatic logic av_of(input pkt_word_t w);
    return w[9];
  endfunction

  function automatic logic [RP_ARG_W-1:0] arg_of(input pkt_word_t w);
    return {w[11], w[10], w[8], w[7], w[6], w[5], w[4], w[3], w[2], w[1], w[0]};
  endfunction

  function automatic logic addr_hit(input pkt_word_t w, input logic [RP_DEV_W-1:0] id);
    pair_e p;
    p = pair_of(w);
    if (p == PAIR_ALL)  return 1'b1;
    if (p == PAIR_NONE) return 1'b0;
    return dev_of(w) == id;
  endfunction

endpackage

// File: rtl/rp_frame_ctrl.sv
module rp_frame_ctrl #(
  parameter int unsigned BEATS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  output logic [BEATS-1:0] beat_en,
  output logic             frame_last
);
  localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  logic             busy;
  logic [CNT_W-1:0] beat_idx;

  always_comb begin
    beat_en = '0;
    if (!busy) beat_en[0] = start_req;
    else       beat_en[beat_idx] = 1'b1;
  end

  assign frame_last = beat_en[BEATS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      beat_idx <= '0;
    end else if (!busy) begin
      if (start_req) begin
        busy     <= 1'b1;
        beat_idx <= CNT_W'(1);
      end
    end else if (beat_idx == LAST_IDX) begin
      busy     <= 1'b0;
      beat_idx <= '0;
    end else begin
      beat_idx <= beat_idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rp_beat_store.sv
module rp_beat_store #(
  parameter int unsigned WIRES = 3,
  parameter int unsigned BEATS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WIRES-1:0]            early,
  input  logic [WIRES-1:0]            late,
  input  logic [BEATS-2:0]            load_en,
  output logic [2*WIRES*BEATS-1:0]    pkt_word
);
  localparam int unsigned BEAT_W = 2 * WIRES;
  localparam int unsigned PKT_W  = BEAT_W * BEATS;

  genvar k;
  generate
    for (k = 0; k < BEATS - 1; k++) begin : g_slot
      logic [BEAT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (rst)             slot_q <= '0;
        else if (load_en[k]) slot_q <= {early, late};
      end
      assign pkt_word[PKT_W-1-k*BEAT_W -: BEAT_W] = slot_q;
    end
  endgenerate

  // final beat is used straight from the bus
  assign pkt_word[BEAT_W-1:0] = {early, late};
endmodule

// File: rtl/rp_field_decode.sv
module rp_field_decode
  import row_pkt_pkg::*;
(
  input  pkt_word_t             pkt_word,
  input  logic [RP_DEV_W-1:0]   my_id,
  output row_fields_t           fields,
  output logic                  hit
);
  always_comb begin
    fields.bcast    = (pair_of(pkt_word) == PAIR_ALL);
    fields.activate = av_of(pkt_word);
    fields.dev      = dev_of(pkt_word);
    fields.bank     = bank_of(pkt_word);
    fields.arg      = arg_of(pkt_word);
    hit             = addr_hit(pkt_word, my_id);
  end
endmodule

// File: rtl/rp_status.sv
module rp_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst)          active <= 1'b0;
    else if (set_evt) active <= 1'b1;
    else if (clr_evt) active <= 1'b0;
  end
endmodule

// File: rtl/row_pkt_rx.sv
module row_pkt_rx
  import row_pkt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RP_DEV_W-1:0]  dev_id,
  input  logic [RP_WIRES-1:0]  ctl_early,
  input  logic [RP_WIRES-1:0]  ctl_late,
  input  logic                 active_clear,
  output logic                 pkt_valid,
  output logic                 pkt_bcast,
  output logic                 pkt_activate,
  output logic [RP_DEV_W-1:0]  pkt_dev,
  output logic [RP_BANK_W-1:0] pkt_bank,
  output logic [RP_ARG_W-1:0]  pkt_arg,
  output logic                 dev_active
);
  // named internal events
  logic                 start_req;
  logic [RP_BEATS-1:0]  beat_en;
  logic                 frame_last;
  pkt_word_t            pkt_word;
  row_fields_t          dec_fields;
  logic                 dec_hit;
  logic                 accept_evt;
  logic                 act_set;

  assign start_req = (ctl_early[RP_WIRES-1 -: 2] != PAIR_NONE);

  rp_frame_ctrl #(.BEATS(RP_BEATS)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .beat_en    (beat_en),
    .frame_last (frame_last)
  );

  rp_beat_store #(.WIRES(RP_WIRES), .BEATS(RP_BEATS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .early    (ctl_early),
    .late     (ctl_late),
    .load_en  (beat_en[RP_BEATS-2:0]),
    .pkt_word (pkt_word)
  );

  rp_field_decode u_decode (
    .pkt_word (pkt_word),
    .my_id    (dev_id),
    .fields   (dec_fields),
    .hit      (dec_hit)
  );

  assign accept_evt = frame_last && dec_hit;
  assign act_set    = accept_evt && dec_fields.activate && !dec_fields.bcast;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid    <= 1'b0;
      pkt_bcast    <= 1'b0;
      pkt_activate <= 1'b0;
      pkt_dev      <= '0;
      pkt_bank     <= '0;
      pkt_arg      <= '0;
    end else begin
      pkt_valid <= accept_evt;
      if (accept_evt) begin
        pkt_bcast    <= dec_fields.bcast;
        pkt_activate <= dec_fields.activate;
        pkt_dev      <= dec_fields.bcast ? {1'b0, dec_fields.dev[RP_DEV_W-2:0]}
                                         : dec_fields.dev;
        pkt_bank     <= dec_fields.bank;
        pkt_arg      <= dec_fields.arg;
      end
    end
  end

  rp_status u_status (
    .clk     (clk),
    .rst     (rst),
    .set_evt (act_set),
    .clr_evt (active_clear),
    .active  (dev_active)
  );
endmodule

// File: rtl/rp_rx_chk.sv
module rp_rx_chk
  import row_pkt_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                active_clear,
  input logic [RP_DEV_W-1:0] dev_id,
  input logic                pkt_valid,
  input logic                pkt_bcast,
  input logic                pkt_activate,
  input logic [RP_DEV_W-1:0] pkt_dev,
  input logic                dev_active,
  input logic [RP_BEATS-1:0] beat_en,
  input logic                frame_last
);
  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!pkt_valid && !dev_active));

  assert_one_beat_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(beat_en));

  genvar k;
  generate
    for (k = 0; k < RP_BEATS - 1; k++) begin : g_order
      assert_beat_order_R1: assert property (@(posedge clk) disable iff (rst)
        beat_en[k] |=> beat_en[k+1]);
    end
  endgenerate

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);

  assert_strobe_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> $past(frame_last));

  assert_addr_match_R3: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_bcast) |-> (pkt_dev == $past(dev_id)));

  assert_activate_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_activate && !pkt_bcast) |-> dev_active);

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && (pkt_bcast || !pkt_activate))
      |-> (dev_active == ($past(dev_active) && !$past(active_clear))));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(active_clear) && !(pkt_valid && pkt_activate && !pkt_bcast))
      |-> !dev_active);
endmodule

bind row_pkt_rx rp_rx_chk u_rx_chk (
  .clk          (clk),
  .rst          (rst),
  .active_clear (active_clear),
  .dev_id       (dev_id),
  .pkt_valid    (pkt_valid),
  .pkt_bcast    (pkt_bcast),
  .pkt_activate (pkt_activate),
  .pkt_dev      (pkt_dev),
  .dev_active   (dev_active),
  .beat_en      (beat_en),
  .frame_last   (frame_last)
);

// File: tb/row_pkt_rx_tb.sv
module row_pkt_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dev_id = '0;
  logic [2:0]  ctl_early = '0;
  logic [2:0]  ctl_late = '0;
  logic        active_clear = 1'b0;
  logic        pkt_valid, pkt_bcast, pkt_activate, dev_active;
  logic [4:0]  pkt_dev, pkt_bank;
  logic [10:0] pkt_arg;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_act = 1'b0;

  always #10 clk = ~clk;

  row_pkt_rx u_dut (
    .clk(clk), .rst(rst), .dev_id(dev_id), .ctl_early(ctl_early),
    .ctl_late(ctl_late), .active_clear(active_clear), .pkt_valid(pkt_valid),
    .pkt_bcast(pkt_bcast), .pkt_activate(pkt_activate), .pkt_dev(pkt_dev),
    .pkt_bank(pkt_bank), .pkt_arg(pkt_arg), .dev_active(dev_active)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-wire tables, half-cycle 0 in the MSB.
  function automatic logic [23:0] build(input logic [1:0] pair, input logic [3:0] dlo,
      input logic [4:0] bank, input logic av, input logic [10:0] arg, input logic rev);
    logic [7:0]  t, m, b;
    logic [23:0] w;
    t = {pair[1], dlo[2], bank[0], bank[3], arg[10], arg[8], arg[5], arg[2]};
    m = {pair[0], dlo[1], bank[1], bank[4], arg[9],  arg[7], arg[4], arg[1]};
    b = {dlo[3],  dlo[0], bank[2], rev,     av,      arg[6], arg[3], arg[0]};
    w = '0;
    for (int h = 0; h < 8; h++) begin
      w[23-3*h] = t[7-h];
      w[22-3*h] = m[7-h];
      w[21-3*h] = b[7-h];
    end
    return w;
  endfunction

  task automatic drive_beat(input logic [23:0] w, input int c);
    @(negedge clk);
    ctl_early = w[23-6*c -: 3];
    ctl_late  = w[20-6*c -: 3];
  endtask

  // Compare outputs at the current time against the packet just completed.
  task automatic check_result(input logic [1:0] pair, input logic [3:0] dlo,
      input logic [4:0] bank, input logic av, input logic [10:0] arg,
      input logic clr, input string tag);
    logic       hit;
    logic [4:0] edev;
    hit  = (pair == 2'b11) || (pair != 2'b00 && {pair == 2'b10, dlo} == dev_id);
    edev = (pair == 2'b11) ? {1'b0, dlo} : {pair == 2'b10, dlo};
    if (hit && av && pair != 2'b11) exp_act = 1'b1;
    else if (clr)                   exp_act = 1'b0;
    chk(pkt_valid == hit, {tag, " R3 R4"}, "valid", int'(pkt_valid), int'(hit));
    if (hit) begin
      chk(pkt_bcast == (pair == 2'b11), {tag, " R2"}, "bcast", int'(pkt_bcast), int'(pair == 2'b11));
      chk(pkt_dev == edev, {tag, " R2 R5"}, "dev", int'(pkt_dev), int'(edev));
      chk(pkt_bank == bank, {tag, " R5"}, "bank", int'(pkt_bank), int'(bank));
      chk(pkt_activate == av, {tag, " R6"}, "activate", int'(pkt_activate), int'(av));
      chk(pkt_arg == arg, {tag, " R6"}, "arg", int'(pkt_arg), int'(arg));
    end
    chk(dev_active == exp_act, {tag, " R8 R9 R10"}, "dev_active", int'(dev_active), int'(exp_act));
  endtask

  task automatic send(input logic [1:0] pair, input logic [3:0] dlo,
      input logic [4:0] bank, input logic av, input logic [10:0] arg,
      input logic rev, input logic clr_last, input string tag);
    logic [23:0] w;
    w = build(pair, dlo, bank, av, arg, rev);
    for (int c = 0; c < 4; c++) begin
      drive_beat(w, c);
      if (c == 3) active_clear = clr_last;
    end
    @(negedge clk);
    check_result(pair, dlo, bank, av, arg, clr_last, tag);
    ctl_early = '0;
    ctl_late  = '0;
    active_clear = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [23:0] w0, w1;
    // Reset state (R11)
    repeat (3) @(negedge clk);
    chk(!pkt_valid, "R11", "reset valid", int'(pkt_valid), 0);
    chk(!dev_active, "R11", "reset active", int'(dev_active), 0);
    rst = 1'b0;

    // R1: idle noise with pair 00 starts nothing
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!pkt_valid, "R1", "noise valid", int'(pkt_valid), 0);
      ctl_early = {2'b00, i[0]};
      ctl_late  = 3'(i);
    end
    @(negedge clk);
    chk(!pkt_valid, "R1", "noise valid", int'(pkt_valid), 0);
    ctl_early = '0; ctl_late = '0;
    @(negedge clk);
    chk(!pkt_valid, "R1", "noise valid", int'(pkt_valid), 0);

    // Main sweep: every id against every address, both kinds (R2 R3 R5 R6 R8 R9)
    for (int id = 0; id < 32; id++) begin
      dev_id = 5'(id);
      for (int a = 0; a < 32; a++) begin
        for (int av = 0; av < 2; av++) begin
          send(a[4] ? 2'b10 : 2'b01, 4'(a), 5'((a * 7 + id) % 32), av[0],
               11'((a * 97 + id * 13 + av * 611) % 2048), a[0], 1'b0, "sweep");
        end
        if (a == 31) begin
          // broadcast of both kinds (R2 R9)
          send(2'b11, 4'(id), 5'(id), 1'b1, 11'(id * 61), 1'b1, 1'b0, "bcast");
          send(2'b11, 4'(~id), 5'(~id), 1'b0, 11'(2047 - id), 1'b0, 1'b0, "bcast");
        end
      end
      // clear between ids (R10)
      @(negedge clk); active_clear = 1'b1;
      @(negedge clk); active_clear = 1'b0; exp_act = 1'b0;
      chk(dev_active == 1'b0, "R10", "clear", int'(dev_active), 0);
    end

    // R9: broadcast activate does not set status from standby
    dev_id = 5'd9;
    send(2'b11, 4'd9, 5'd3, 1'b1, 11'h7ff, 1'b0, 1'b0, "R9 bcast standby");
    // R8 then R10: activate and clear at the same edge -> activation wins
    send(2'b01, 4'd9, 5'd4, 1'b1, 11'h155, 1'b0, 1'b1, "R10 tie");
    chk(dev_active == 1'b1, "R10", "tie", int'(dev_active), 1);
    // R9: operation packet keeps active
    send(2'b01, 4'd9, 5'd4, 1'b0, 11'h2aa, 1'b1, 1'b0, "R9 op");
    // R8: activate again while active
    send(2'b01, 4'd9, 5'd0, 1'b1, 11'h001, 1'b0, 1'b0, "R8 again");

    // R7: back-to-back packets, no idle cycle
    w0 = build(2'b01, 4'd9, 5'd17, 1'b1, 11'h4c3, 1'b1);
    w1 = build(2'b11, 4'd5, 5'd30, 1'b0, 11'h13a, 1'b0);
    for (int c = 0; c < 4; c++) drive_beat(w0, c);
    @(negedge clk);
    check_result(2'b01, 4'd9, 5'd17, 1'b1, 11'h4c3, 1'b0, "R7 first");
    ctl_early = w1[23 -: 3]; ctl_late = w1[20 -: 3];
    for (int c = 1; c < 4; c++) drive_beat(w1, c);
    @(negedge clk);
    check_result(2'b11, 4'd5, 5'd30, 1'b0, 11'h13a, 1'b0, "R7 second");
    ctl_early = '0; ctl_late = '0;

    // R11: reset in the middle of a packet drops it and clears status
    w0 = build(2'b01, 4'd9, 5'd1, 1'b1, 11'h000, 1'b0);
    drive_beat(w0, 0);
    drive_beat(w0, 1);
    @(negedge clk); rst = 1'b1; ctl_early = '0; ctl_late = '0;
    @(negedge clk); rst = 1'b0; exp_act = 1'b0;
    ctl_early = w0[11 -: 3]; ctl_late = w0[8 -: 3];
    drive_beat(w0, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!pkt_valid, "R11", "mid-packet reset valid", int'(pkt_valid), 0);
      chk(!dev_active, "R11", "mid-packet reset active", int'(dev_active), 0);
      ctl_early = '0; ctl_late = '0;
    end

    // R3: mismatching id with nonzero pair gives no strobe
    send(2'b10, 4'd9, 5'd2, 1'b1, 11'h3ff, 1'b0, 1'b0, "R3 miss");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule